// File: doc/BRIEF.md
# Packed Dual-DAC Register Interface

This block sits on a byte-wide host bus behind an external address decoder. It holds two 12-bit converter codes, a scale code and an offset code, and one control byte. The two codes are loaded with only three byte writes. Each code has its own low-byte latch. A third, shared byte carries the upper nibble of both codes. Low bytes wait in shadow registers. Both parallel DAC outputs change together on the clock edge that captures the shared byte, so a converter never sees a code that is only half written.

On the read side, the block returns two 9-bit calibration switch values through separate enables. The low switch value calibrates the offset code and the high switch value calibrates the scale code. The ninth bit of each switch value does not fit in the byte, so it comes back through a shared status port. That status port also returns an active-low unleveled-power flag and the live level of the retrace strobe. The control byte drives active-low control lines, and reset makes every one of them inactive.

All write strobes and read enables are active low. Writes are sampled on the rising clock edge. Reads are combinational from the enables and the switch inputs. The bus has no back-pressure: every strobe that is sampled low is accepted in that cycle.

Top module: `dacreg_top`

## Requirements
- R1: While reset is asserted, and after reset is released, both code outputs and both shadow bytes are zero and the control output is all ones (8'hFF).
- R2: A clock edge that samples `nib_wr_n` low loads `scale_code` with {wdata[3:0], scale shadow} and `offset_code` with {wdata[7:4], offset shadow}. Both outputs change on that same edge.
- R3: A clock edge that samples a low-byte strobe (`scale_lo_wr_n` or `offset_lo_wr_n`) without `nib_wr_n` updates only that shadow byte. Both code outputs are left unchanged.
- R4: If a low-byte strobe and `nib_wr_n` are sampled low on the same edge, the code is assembled from the new bus byte, not from the old shadow byte.
- R5: A clock edge that samples `ctrl_wr_n` low loads the bus byte into `ctrl_lines`. At all other edges `ctrl_lines` holds its value, including when code bytes are written.
- R6: While only `cal_lo_rd_n` is low, `rdata` equals `cal_lo_sw[7:0]`.
- R7: While only `cal_hi_rd_n` is low, `rdata` equals `cal_hi_sw[7:0]`.
- R8: While only `stat_rd_n` is low, `rdata` has this layout:
  - bit 0 = `cal_lo_sw[8]`
  - bit 1 = `cal_hi_sw[8]`
  - bit 2 = `unlvl_n`
  - bit 3 = `retrace_n`
  - bits 7:4 = 0
- R9: While no read enable is low, or while more than one is low, `rdata` is zero.
- R10: A shadow byte persists across shared-nibble writes. A second nibble write with no low-byte write in between reuses the same low bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdata | input | 8 | Host write data byte |
| scale_lo_wr_n | input | 1 | Write strobe for the scale code low byte (active low) |
| offset_lo_wr_n | input | 1 | Write strobe for the offset code low byte (active low) |
| nib_wr_n | input | 1 | Write strobe for the shared upper-nibble byte; commits both codes (active low) |
| ctrl_wr_n | input | 1 | Write strobe for the control byte (active low) |
| cal_lo_sw | input | 9 | Low-end calibration switch value |
| cal_hi_sw | input | 9 | High-end calibration switch value |
| unlvl_n | input | 1 | Unleveled-power flag (active low) |
| retrace_n | input | 1 | Retrace strobe level |
| cal_lo_rd_n | input | 1 | Read enable for the low calibration byte (active low) |
| cal_hi_rd_n | input | 1 | Read enable for the high calibration byte (active low) |
| stat_rd_n | input | 1 | Read enable for the status byte (active low) |
| rdata | output | 8 | Host read data byte |
| scale_code | output | 12 | Parallel code to the scale DAC |
| offset_code | output | 12 | Parallel code to the offset DAC |
| ctrl_lines | output | 8 | Latched control byte |

## Verification
The bench writes low bytes alone and checks that the DAC outputs do not move. A design that passes low bytes straight to the outputs would show a half-updated code there. It also writes a low byte and the nibble byte on the same edge; a design without the bypass path would commit the stale shadow byte. It repeats nibble writes to check that the shadow bytes persist, and checks that the control byte survives code writes. On the read side, it checks the exact status bit positions under two different input patterns, and checks that zero is returned when no enable or two enables are active. A mux that only prioritised enables would return data in the two-enable case.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
  // status byte bit positions (host firmware decodes these)
  localparam int STAT_CAL_LO_BIT  = 0;
  localparam int STAT_CAL_HI_BIT  = 1;
  localparam int STAT_UNLVL_BIT   = 2;
  localparam int STAT_RETRACE_BIT = 3;

  // channel indices inside the code path
  localparam int CH_SCALE  = 0;
  localparam int CH_OFFSET = 1;
  localparam int N_CH      = 2;

  typedef enum logic [1:0] {
    SRC_NONE,
    SRC_CAL_LO,
    SRC_CAL_HI,
    SRC_STATUS
  } rd_src_e;
endpackage

// File: rtl/dacreg_shadow.sv
module dacreg_shadow
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [N_CH-1:0]               lo_wr_n,
  input  logic                          ctrl_wr_n,
  output logic [N_CH-1:0][DATA_W-1:0]   shadow_q,
  output logic [DATA_W-1:0]             ctrl_q
);
  // one low-byte shadow per channel
  for (genvar ch = 0; ch < N_CH; ch++) begin : g_lo
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              shadow_q[ch] <= '0;
      else if (!lo_wr_n[ch])   shadow_q[ch] <= wdata;
    end
  end

  // control byte resets to all ones: every active-low line idle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ctrl_q <= '1;
    else if (!ctrl_wr_n) ctrl_q <= wdata;
  end
endmodule

// File: rtl/dacreg_commit.sv
module dacreg_commit
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [N_CH-1:0]               lo_wr_n,
  input  logic                          nib_wr_n,
  input  logic [N_CH-1:0][DATA_W-1:0]   shadow_q,
  output logic [N_CH-1:0][CODE_W-1:0]   code_q
);
  localparam int NIB_W = CODE_W - DATA_W;

  for (genvar ch = 0; ch < N_CH; ch++) begin : g_ch
    logic [DATA_W-1:0] lo_byte;
    logic [NIB_W-1:0]  hi_nib;

    // same-edge low-byte write bypasses the shadow
    always_comb begin
      lo_byte = lo_wr_n[ch] ? shadow_q[ch] : wdata;
      hi_nib  = wdata[ch*NIB_W +: NIB_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         code_q[ch] <= '0;
      else if (!nib_wr_n) code_q[ch] <= {hi_nib, lo_byte};
    end
  end
endmodule

// File: rtl/dacreg_rdmux.sv
module dacreg_rdmux
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CAL_W  = 9
) (
  input  logic [CAL_W-1:0]  cal_lo_sw,
  input  logic [CAL_W-1:0]  cal_hi_sw,
  input  logic              unlvl_n,
  input  logic              retrace_n,
  input  logic [2:0]        rd_n,
  output logic [DATA_W-1:0] rdata
);
  rd_src_e           src;
  logic [DATA_W-1:0] stat_byte;
  logic [2:0]        rd_act;

  always_comb begin
    stat_byte                   = '0;
    stat_byte[STAT_CAL_LO_BIT]  = cal_lo_sw[CAL_W-1];
    stat_byte[STAT_CAL_HI_BIT]  = cal_hi_sw[CAL_W-1];
    stat_byte[STAT_UNLVL_BIT]   = unlvl_n;
    stat_byte[STAT_RETRACE_BIT] = retrace_n;
  end

  // decode: only a single active enable selects a source
  always_comb begin
    rd_act = ~rd_n;
    unique case (rd_act)
      3'b001:  src = SRC_CAL_LO;
      3'b010:  src = SRC_CAL_HI;
      3'b100:  src = SRC_STATUS;
      default: src = SRC_NONE;
    endcase
  end

  always_comb begin
    unique case (src)
      SRC_CAL_LO: rdata = cal_lo_sw[DATA_W-1:0];
      SRC_CAL_HI: rdata = cal_hi_sw[DATA_W-1:0];
      SRC_STATUS: rdata = stat_byte;
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/dacreg_top.sv
module dacreg_top
  import dacreg_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12,
  parameter int CAL_W  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] wdata,
  input  logic              scale_lo_wr_n,
  input  logic              offset_lo_wr_n,
  input  logic              nib_wr_n,
  input  logic              ctrl_wr_n,
  input  logic [CAL_W-1:0]  cal_lo_sw,
  input  logic [CAL_W-1:0]  cal_hi_sw,
  input  logic              unlvl_n,
  input  logic              retrace_n,
  input  logic              cal_lo_rd_n,
  input  logic              cal_hi_rd_n,
  input  logic              stat_rd_n,
  output logic [DATA_W-1:0] rdata,
  output logic [CODE_W-1:0] scale_code,
  output logic [CODE_W-1:0] offset_code,
  output logic [DATA_W-1:0] ctrl_lines
);
  logic [N_CH-1:0]               lo_wr_n;
  logic [N_CH-1:0][DATA_W-1:0]   shadow_q;
  logic [N_CH-1:0][CODE_W-1:0]   code_q;

  always_comb begin
    lo_wr_n[CH_SCALE]  = scale_lo_wr_n;
    lo_wr_n[CH_OFFSET] = offset_lo_wr_n;
  end

  dacreg_shadow #(.DATA_W(DATA_W)) u_shadow (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdata     (wdata),
    .lo_wr_n   (lo_wr_n),
    .ctrl_wr_n (ctrl_wr_n),
    .shadow_q  (shadow_q),
    .ctrl_q    (ctrl_lines)
  );

  dacreg_commit #(.DATA_W(DATA_W), .CODE_W(CODE_W)) u_commit (
    .clk      (clk),
    .rst_n    (rst_n),
    .wdata    (wdata),
    .lo_wr_n  (lo_wr_n),
    .nib_wr_n (nib_wr_n),
    .shadow_q (shadow_q),
    .code_q   (code_q)
  );

  dacreg_rdmux #(.DATA_W(DATA_W), .CAL_W(CAL_W)) u_rdmux (
    .cal_lo_sw (cal_lo_sw),
    .cal_hi_sw (cal_hi_sw),
    .unlvl_n   (unlvl_n),
    .retrace_n (retrace_n),
    .rd_n      ({stat_rd_n, cal_hi_rd_n, cal_lo_rd_n}),
    .rdata     (rdata)
  );

  always_comb begin
    scale_code  = code_q[CH_SCALE];
    offset_code = code_q[CH_OFFSET];
  end
endmodule

// File: rtl/dacreg_chk.sv
module dacreg_chk #(
  parameter int DATA_W = 8,
  parameter int CODE_W = 12,
  parameter int CAL_W  = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] wdata,
  input logic              scale_lo_wr_n,
  input logic              offset_lo_wr_n,
  input logic              nib_wr_n,
  input logic              ctrl_wr_n,
  input logic [CAL_W-1:0]  cal_lo_sw,
  input logic              cal_lo_rd_n,
  input logic              cal_hi_rd_n,
  input logic              stat_rd_n,
  input logic [DATA_W-1:0] rdata,
  input logic [CODE_W-1:0] scale_code,
  input logic [CODE_W-1:0] offset_code,
  input logic [DATA_W-1:0] ctrl_lines
);
  localparam int NIB_W = CODE_W - DATA_W;

  AST_RST_VALUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (scale_code == '0 && offset_code == '0 && ctrl_lines == '1)); // R1

  AST_PAIR_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    !nib_wr_n |=> (scale_code[CODE_W-1:DATA_W] == $past(wdata[NIB_W-1:0]) &&
                   offset_code[CODE_W-1:DATA_W] == $past(wdata[2*NIB_W-1:NIB_W]))); // R2

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    nib_wr_n |=> ($stable(scale_code) && $stable(offset_code))); // R3

  AST_LO_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_wr_n && !scale_lo_wr_n) |=> (scale_code[DATA_W-1:0] == $past(wdata))); // R4

  AST_OFS_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_wr_n && !offset_lo_wr_n) |=> (offset_code[DATA_W-1:0] == $past(wdata))); // R4

  AST_CTRL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr_n |=> (ctrl_lines == $past(wdata))); // R5

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr_n |=> $stable(ctrl_lines)); // R5

  AST_RD_CAL_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_lo_rd_n && cal_hi_rd_n && stat_rd_n) |-> (rdata == cal_lo_sw[DATA_W-1:0])); // R6

  AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones({cal_lo_rd_n, cal_hi_rd_n, stat_rd_n}) != 2) |-> (rdata == '0)); // R9
endmodule

bind dacreg_top dacreg_chk #(.DATA_W(DATA_W), .CODE_W(CODE_W), .CAL_W(CAL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .wdata          (wdata),
  .scale_lo_wr_n  (scale_lo_wr_n),
  .offset_lo_wr_n (offset_lo_wr_n),
  .nib_wr_n       (nib_wr_n),
  .ctrl_wr_n      (ctrl_wr_n),
  .cal_lo_sw      (cal_lo_sw),
  .cal_lo_rd_n    (cal_lo_rd_n),
  .cal_hi_rd_n    (cal_hi_rd_n),
  .stat_rd_n      (stat_rd_n),
  .rdata          (rdata),
  .scale_code     (scale_code),
  .offset_code    (offset_code),
  .ctrl_lines     (ctrl_lines)
);

// File: tb/dacreg_tb.sv
module dacreg_top_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] wdata = '0;
  logic       scale_lo_wr_n = 1'b1, offset_lo_wr_n = 1'b1, nib_wr_n = 1'b1, ctrl_wr_n = 1'b1;
  logic [8:0] cal_lo_sw = '0, cal_hi_sw = '0;
  logic       unlvl_n = 1'b1, retrace_n = 1'b0;
  logic       cal_lo_rd_n = 1'b1, cal_hi_rd_n = 1'b1, stat_rd_n = 1'b1;
  logic [7:0] rdata;
  logic [11:0] scale_code, offset_code;
  logic [7:0] ctrl_lines;

  always #(CLK_P/2) clk = ~clk;

  dacreg_top dut_i (
    .clk(clk), .rst_n(rst_n), .wdata(wdata),
    .scale_lo_wr_n(scale_lo_wr_n), .offset_lo_wr_n(offset_lo_wr_n),
    .nib_wr_n(nib_wr_n), .ctrl_wr_n(ctrl_wr_n),
    .cal_lo_sw(cal_lo_sw), .cal_hi_sw(cal_hi_sw),
    .unlvl_n(unlvl_n), .retrace_n(retrace_n),
    .cal_lo_rd_n(cal_lo_rd_n), .cal_hi_rd_n(cal_hi_rd_n), .stat_rd_n(stat_rd_n),
    .rdata(rdata), .scale_code(scale_code), .offset_code(offset_code),
    .ctrl_lines(ctrl_lines)
  );

  // scoreboard item: kind 0 = codes, 1 = control, 2 = read byte
  typedef struct {
    int          kind;
    string       req;
    logic [11:0] es;
    logic [11:0] eo;
    logic [7:0]  ev;
  } item_t;

  item_t q[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  // reference model state
  logic [7:0]  m_slo, m_olo, m_ctrl;
  logic [11:0] m_scale, m_off;

  // monitor: compares a quarter period after each rising edge
  always @(posedge clk) begin
    item_t it;
    #(CLK_P/4);
    while (q.size() > 0) begin
      it = q.pop_front();
      n_tests++;
      case (it.kind)
        0: if (scale_code !== it.es || offset_code !== it.eo) begin
             n_fail++;
             $display("FAIL %s: scale=%h offset=%h expected scale=%h offset=%h",
                      it.req, scale_code, offset_code, it.es, it.eo);
           end
        1: if (ctrl_lines !== it.ev) begin
             n_fail++;
             $display("FAIL %s: ctrl=%h expected %h", it.req, ctrl_lines, it.ev);
           end
        default: if (rdata !== it.ev) begin
             n_fail++;
             $display("FAIL %s: rdata=%h expected %h", it.req, rdata, it.ev);
           end
      endcase
    end
  end

  task automatic push_codes(input string r);
    item_t it;
    it.kind = 0; it.req = r; it.es = m_scale; it.eo = m_off; it.ev = '0;
    q.push_back(it);
  endtask

  task automatic push_ctrl(input string r);
    item_t it;
    it.kind = 1; it.req = r; it.es = '0; it.eo = '0; it.ev = m_ctrl;
    q.push_back(it);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    m_slo = '0; m_olo = '0; m_scale = '0; m_off = '0; m_ctrl = 8'hFF;
  endtask

  // driver: strobes chosen bytes for one edge, then updates the model
  task automatic wr(input bit s_lo, input bit o_lo, input bit nib, input bit ctl,
                    input logic [7:0] d);
    @(negedge clk);
    wdata = d;
    scale_lo_wr_n = !s_lo; offset_lo_wr_n = !o_lo; nib_wr_n = !nib; ctrl_wr_n = !ctl;
    @(negedge clk);
    scale_lo_wr_n = 1'b1; offset_lo_wr_n = 1'b1; nib_wr_n = 1'b1; ctrl_wr_n = 1'b1;
    if (s_lo) m_slo = d;
    if (o_lo) m_olo = d;
    if (nib) begin
      m_scale = {d[3:0], m_slo};
      m_off   = {d[7:4], m_olo};
    end
    if (ctl) m_ctrl = d;
  endtask

  task automatic rd(input bit a, input bit b, input bit c, input logic [7:0] exp,
                    input string r);
    item_t it;
    @(negedge clk);
    cal_lo_rd_n = !a; cal_hi_rd_n = !b; stat_rd_n = !c;
    it.kind = 2; it.req = r; it.es = '0; it.eo = '0; it.ev = exp;
    q.push_back(it);
    @(negedge clk);
    cal_lo_rd_n = 1'b1; cal_hi_rd_n = 1'b1; stat_rd_n = 1'b1;
  endtask

  function automatic logic [7:0] stat_exp();
    return {4'b0000, retrace_n, unlvl_n, cal_hi_sw[8], cal_lo_sw[8]};
  endfunction

  initial begin
    do_reset();
    push_codes("R1 reset codes"); push_ctrl("R1 reset ctrl");
    @(negedge clk);

    wr(0, 0, 1, 0, 8'hA5);                 // zero shadows after reset
    push_codes("R1 R2 shadow reset, nibble commit");
    @(negedge clk);

    wr(1, 0, 0, 0, 8'h3C);
    push_codes("R3 scale low byte held");
    @(negedge clk);
    wr(0, 1, 0, 0, 8'hC7);
    push_codes("R3 offset low byte held");
    @(negedge clk);

    wr(0, 0, 1, 0, 8'h9E);
    push_codes("R2 paired commit");        // E3C / 9C7
    @(negedge clk);
    wr(0, 0, 1, 0, 8'h12);
    push_codes("R10 shadow reused");       // 23C / 1C7
    @(negedge clk);

    wr(1, 0, 1, 0, 8'h6B);
    push_codes("R4 same-edge bypass");     // B6B / 6C7
    @(negedge clk);
    wr(0, 1, 1, 0, 8'hD4);
    push_codes("R4 same-edge offset bypass");
    @(negedge clk);

    wr(0, 0, 0, 1, 8'h5A);
    push_ctrl("R5 control capture");
    @(negedge clk);
    wr(1, 1, 1, 0, 8'h0F);
    push_ctrl("R5 control held over code writes");
    push_codes("R2 R4 all strobes");
    @(negedge clk);

    cal_lo_sw = 9'h1A3; cal_hi_sw = 9'h0F0; unlvl_n = 1'b0; retrace_n = 1'b1;
    rd(1, 0, 0, 8'hA3, "R6 cal low read");
    rd(0, 1, 0, 8'hF0, "R7 cal high read");
    rd(0, 0, 1, stat_exp(), "R8 status pattern A");   // 09
    cal_lo_sw = 9'h055; cal_hi_sw = 9'h1C2; unlvl_n = 1'b1; retrace_n = 1'b0;
    rd(0, 0, 1, stat_exp(), "R8 status pattern B");   // 06
    rd(1, 0, 0, 8'h55, "R6 cal low read B");
    rd(0, 0, 0, 8'h00, "R9 no enable");
    rd(1, 1, 0, 8'h00, "R9 two enables");
    rd(1, 1, 1, 8'h00, "R9 three enables");

    do_reset();
    push_codes("R1 reset after activity"); push_ctrl("R1 ctrl after activity");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule